// File: doc/BRIEF.md
# Operand Forwarding and Load-Use Interlock

This block holds the hazard logic of a five-stage in-order integer pipeline with fetch, decode/register read, execute, memory and writeback stages. It owns the decode-to-execute control register. For the instruction now in execute, it picks each ALU operand from one of three places: the register file, the memory/writeback pipeline register, or the execute/memory pipeline register. To make that choice it compares the instruction's two source register numbers with the destinations and write enables of the two later stages.

The block also catches a load in execute whose destination is a source of the instruction in decode. In that cycle it holds the PC and the fetch/decode register, and it loads an all-zero control bundle into the execute stage in place of the decoded one. The stall therefore lasts exactly one cycle. The register file is assumed to return a value written in the same cycle it is read, so writeback needs no third bypass path.

Top module: `hazard_ctrl`

## Requirements
- R1: After synchronous reset, `ex_ctrl` and `ex_dst` are zero, both operand selects are 0 and the hold outputs are low.
- R2: An operand select is 2 (take the execute/memory result) when that stage's write enable is high, its destination is nonzero and it equals the operand's source register.
- R3: An operand select is 1 (take the memory/writeback result) when only the memory/writeback stage has write enable high, a nonzero destination and a matching source.
- R4: When both later stages match the same source, the select is 2, because the execute/memory stage holds the younger result.
- R5: A stage whose destination is register 0, or whose write enable is low, never causes forwarding. The select is 0 (register file) when no stage qualifies.
- R6: Bit 0 of the control bundle is register write and bit 1 is load. When the execute stage holds a control bundle with both bits set and a nonzero destination equal to either source of the decode instruction, `hold_pc` and `hold_fd` are high in that same cycle.
- R7: On the clock edge that ends a stall cycle, `ex_ctrl` and `ex_dst` become zero (a bubble).
- R8: The cycle after a stall cycle never stalls, so the stall lasts exactly one cycle.
- R9: No stall occurs for a dependency on a non-load instruction, on a load writing register 0, or on a bundle whose write bit is low.
- R10: Outside a stall, `ex_ctrl` and `ex_dst` take the decode-stage control bundle and destination on the next clock edge.
- R11: The two operand selects are worked out independently, each from its own source register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| id_src_a | input | RW | First source register of the decode instruction |
| id_src_b | input | RW | Second source register of the decode instruction |
| id_dst | input | RW | Destination register of the decode instruction |
| id_ctrl | input | CW | Control bundle from decode (bit 0 register write, bit 1 load) |
| xm_dst | input | RW | Destination held in the execute/memory register |
| xm_wen | input | 1 | Register write enable of the execute/memory stage |
| mw_dst | input | RW | Destination held in the memory/writeback register |
| mw_wen | input | 1 | Register write enable of the memory/writeback stage |
| hold_pc | output | 1 | Keep the PC unchanged this cycle |
| hold_fd | output | 1 | Keep the fetch/decode register unchanged this cycle |
| ex_ctrl | output | CW | Control bundle of the instruction in execute |
| ex_dst | output | RW | Destination register of the instruction in execute |
| fwd_sel_a | output | 2 | First ALU operand source: 0 register file, 1 writeback, 2 execute/memory |
| fwd_sel_b | output | 2 | Second ALU operand source, same coding |

## Verification
A stale source register or destination in the execute register shows up as a wrong operand select in the very next cycle. A wrong select shows at once on `fwd_sel_a` or `fwd_sel_b`, within the same cycle as the inputs that cause it. A missed or extra interlock shows in the same cycle on the hold outputs. A bubble that was never inserted shows one edge later as a nonzero `ex_ctrl`. A stall that does not end shows as a second held cycle. Because every cycle is compared, these faults surface within one or two clocks of the stimulus that exposes them.

// File: rtl/hzd_pkg.sv
package hzd_pkg;
  typedef enum logic [1:0] {
    FWD_RF = 2'd0,
    FWD_WB = 2'd1,
    FWD_XM = 2'd2
  } fwd_sel_e;

  localparam int CTRL_WEN_BIT  = 0;
  localparam int CTRL_LOAD_BIT = 1;
endpackage

// File: rtl/fwd_select.sv
module fwd_select #(
  parameter int RW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [RW-1:0] src,
  input  logic [RW-1:0] xm_dst,
  input  logic          xm_wen,
  input  logic [RW-1:0] mw_dst,
  input  logic          mw_wen,
  output logic [1:0]    sel
);
  import hzd_pkg::*;

  logic xm_hit, mw_hit;
  fwd_sel_e choice;

  assign xm_hit = xm_wen && (xm_dst != '0) && (xm_dst == src);
  assign mw_hit = mw_wen && (mw_dst != '0) && (mw_dst == src);

  // younger result in execute/memory takes priority
  always_comb begin
    if (xm_hit)      choice = FWD_XM;
    else if (mw_hit) choice = FWD_WB;
    else             choice = FWD_RF;
  end

  assign sel = choice;

  assert_sel_legal_R2: assert property (@(posedge clk) disable iff (rst)
    sel != 2'd3);

  assert_zero_src_R5: assert property (@(posedge clk) disable iff (rst)
    (src == '0) |-> (sel == 2'd0));
endmodule

// File: rtl/load_use_detect.sv
module load_use_detect #(
  parameter int RW = 5
) (
  input  logic          ex_load,
  input  logic          ex_wen,
  input  logic [RW-1:0] ex_dst,
  input  logic [RW-1:0] id_src_a,
  input  logic [RW-1:0] id_src_b,
  output logic          hazard
);
  logic dst_live;

  assign dst_live = ex_load && ex_wen && (ex_dst != '0);
  assign hazard   = dst_live && ((id_src_a == ex_dst) || (id_src_b == ex_dst));
endmodule

// File: rtl/idex_reg.sv
module idex_reg #(
  parameter int RW = 5,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bubble,
  input  logic [RW-1:0] id_src_a,
  input  logic [RW-1:0] id_src_b,
  input  logic [RW-1:0] id_dst,
  input  logic [CW-1:0] id_ctrl,
  output logic [RW-1:0] ex_src_a,
  output logic [RW-1:0] ex_src_b,
  output logic [RW-1:0] ex_dst,
  output logic [CW-1:0] ex_ctrl
);
  always_ff @(posedge clk) begin
    if (rst || bubble) begin
      ex_src_a <= '0;
      ex_src_b <= '0;
      ex_dst   <= '0;
      ex_ctrl  <= '0;
    end else begin
      ex_src_a <= id_src_a;
      ex_src_b <= id_src_b;
      ex_dst   <= id_dst;
      ex_ctrl  <= id_ctrl;
    end
  end

  assert_bubble_zero_R7: assert property (@(posedge clk) disable iff (rst)
    bubble |=> (ex_ctrl == '0) && (ex_dst == '0));

  assert_pass_through_R10: assert property (@(posedge clk) disable iff (rst)
    !bubble |=> (ex_ctrl == $past(id_ctrl)) && (ex_dst == $past(id_dst)));
endmodule

// File: rtl/hazard_ctrl.sv
module hazard_ctrl #(
  parameter int RW = 5,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [RW-1:0] id_src_a,
  input  logic [RW-1:0] id_src_b,
  input  logic [RW-1:0] id_dst,
  input  logic [CW-1:0] id_ctrl,
  input  logic [RW-1:0] xm_dst,
  input  logic          xm_wen,
  input  logic [RW-1:0] mw_dst,
  input  logic          mw_wen,
  output logic          hold_pc,
  output logic          hold_fd,
  output logic [CW-1:0] ex_ctrl,
  output logic [RW-1:0] ex_dst,
  output logic [1:0]    fwd_sel_a,
  output logic [1:0]    fwd_sel_b
);
  import hzd_pkg::*;

  localparam int NUM_OPS = 2;

  logic          stall;
  logic [RW-1:0] ex_src_a, ex_src_b;
  logic [RW-1:0] op_src [NUM_OPS];
  logic [1:0]    op_sel [NUM_OPS];

  load_use_detect #(.RW(RW)) lud_i (
    .ex_load  (ex_ctrl[CTRL_LOAD_BIT]),
    .ex_wen   (ex_ctrl[CTRL_WEN_BIT]),
    .ex_dst   (ex_dst),
    .id_src_a (id_src_a),
    .id_src_b (id_src_b),
    .hazard   (stall)
  );

  idex_reg #(.RW(RW), .CW(CW)) idex_i (
    .clk      (clk),
    .rst      (rst),
    .bubble   (stall),
    .id_src_a (id_src_a),
    .id_src_b (id_src_b),
    .id_dst   (id_dst),
    .id_ctrl  (id_ctrl),
    .ex_src_a (ex_src_a),
    .ex_src_b (ex_src_b),
    .ex_dst   (ex_dst),
    .ex_ctrl  (ex_ctrl)
  );

  assign op_src[0] = ex_src_a;
  assign op_src[1] = ex_src_b;

  for (genvar g = 0; g < NUM_OPS; g++) begin : g_op
    fwd_select #(.RW(RW)) sel_i (
      .clk    (clk),
      .rst    (rst),
      .src    (op_src[g]),
      .xm_dst (xm_dst),
      .xm_wen (xm_wen),
      .mw_dst (mw_dst),
      .mw_wen (mw_wen),
      .sel    (op_sel[g])
    );
  end

  assign fwd_sel_a = op_sel[0];
  assign fwd_sel_b = op_sel[1];
  assign hold_pc   = stall;
  assign hold_fd   = stall;

  assert_single_stall_R8: assert property (@(posedge clk) disable iff (rst)
    hold_pc |=> !hold_pc);

  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (ex_ctrl == '0) && (ex_dst == '0));

  assert_no_alu_stall_R9: assert property (@(posedge clk) disable iff (rst)
    !ex_ctrl[CTRL_LOAD_BIT] |-> !hold_pc);
endmodule

// File: tb/hazard_ctrl_tb.sv
module hazard_ctrl_tb_top;
  localparam int RW = 5;
  localparam int CW = 8;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [RW-1:0] id_src_a = '0, id_src_b = '0, id_dst = '0;
  logic [CW-1:0] id_ctrl = '0;
  logic [RW-1:0] xm_dst = '0, mw_dst = '0;
  logic xm_wen = 1'b0, mw_wen = 1'b0;
  logic hold_pc, hold_fd;
  logic [CW-1:0] ex_ctrl;
  logic [RW-1:0] ex_dst;
  logic [1:0] fwd_sel_a, fwd_sel_b;

  int checks = 0;
  int errors = 0;

  // reference state: instruction sitting in execute
  logic [RW-1:0] m_sa = '0, m_sb = '0, m_dst = '0;
  logic [CW-1:0] m_ctrl = '0;
  bit m_prev_stall = 0;
  bit m_after_reset = 1;

  always #(CLK_PERIOD/2) clk = ~clk;

  hazard_ctrl #(.RW(RW), .CW(CW)) dut_i (
    .clk(clk), .rst(rst),
    .id_src_a(id_src_a), .id_src_b(id_src_b), .id_dst(id_dst), .id_ctrl(id_ctrl),
    .xm_dst(xm_dst), .xm_wen(xm_wen), .mw_dst(mw_dst), .mw_wen(mw_wen),
    .hold_pc(hold_pc), .hold_fd(hold_fd), .ex_ctrl(ex_ctrl), .ex_dst(ex_dst),
    .fwd_sel_a(fwd_sel_a), .fwd_sel_b(fwd_sel_b)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_sel(input logic [RW-1:0] s);
    if (xm_wen && xm_dst != 0 && xm_dst == s) return 2;
    if (mw_wen && mw_dst != 0 && mw_dst == s) return 1;
    return 0;
  endfunction

  function automatic string sel_tag(input logic [RW-1:0] s, input int e);
    bit mw_match;
    mw_match = mw_wen && mw_dst != 0 && mw_dst == s;
    if (e == 2 && mw_match) return "R4";
    if (e == 2) return "R2";
    if (e == 1) return "R3";
    if (xm_dst == s || mw_dst == s) return "R5";
    return "R11";
  endfunction

  task automatic cyc(input int sa, input int sb, input int d, input int c,
                     input int xd, input int xw, input int md, input int mw);
    int ea, eb, es;
    string st;
    @(negedge clk);
    id_src_a = sa[RW-1:0]; id_src_b = sb[RW-1:0]; id_dst = d[RW-1:0]; id_ctrl = c[CW-1:0];
    xm_dst = xd[RW-1:0]; xm_wen = xw[0]; mw_dst = md[RW-1:0]; mw_wen = mw[0];
    #1;
    ea = exp_sel(m_sa);
    eb = exp_sel(m_sb);
    es = (m_ctrl[1] && m_ctrl[0] && m_dst != 0 && (id_src_a == m_dst || id_src_b == m_dst)) ? 1 : 0;
    if (m_after_reset) begin
      check("R1", "ex_ctrl after reset", ex_ctrl, 0);
      check("R1", "ex_dst after reset", ex_dst, 0);
    end else begin
      check(m_prev_stall ? "R7" : "R10", "ex_ctrl", ex_ctrl, m_ctrl);
      check(m_prev_stall ? "R7" : "R10", "ex_dst", ex_dst, m_dst);
    end
    check(sel_tag(m_sa, ea), "fwd_sel_a", fwd_sel_a, ea);
    check(sel_tag(m_sb, eb), "fwd_sel_b", fwd_sel_b, eb);
    st = (es == 1) ? "R6" : (m_prev_stall ? "R8" : "R9");
    check(st, "hold_pc", hold_pc, es);
    check(st, "hold_fd", hold_fd, es);
    @(posedge clk);
    if (es == 1) begin
      m_sa = '0; m_sb = '0; m_dst = '0; m_ctrl = '0;
    end else begin
      m_sa = id_src_a; m_sb = id_src_b; m_dst = id_dst; m_ctrl = id_ctrl;
    end
    m_prev_stall = (es == 1);
    m_after_reset = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: reset state, no hazard inputs
    cyc(0, 0, 0, 0, 0, 0, 0, 0);
    // R2 R3 R11: operand A from execute/memory, operand B from writeback
    cyc(4, 7, 8, 1, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 4, 1, 7, 1);
    // R4: both stages hold the same register
    cyc(6, 6, 2, 1, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 6, 1, 6, 1);
    // R5: destination zero and write enable low
    cyc(0, 5, 3, 1, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 1, 5, 0);
    // R6 R7 R8: load then dependent instruction
    cyc(1, 2, 9, 3, 0, 0, 0, 0);
    cyc(9, 3, 4, 1, 0, 0, 0, 0);
    cyc(9, 3, 4, 1, 0, 0, 9, 1);
    // R9: load to register 0, load with write bit low, ALU producer
    cyc(1, 2, 0, 3, 0, 0, 0, 0);
    cyc(0, 0, 5, 1, 0, 0, 0, 0);
    cyc(1, 2, 10, 2, 0, 0, 0, 0);
    cyc(10, 10, 5, 1, 0, 0, 0, 0);
    cyc(1, 2, 11, 1, 0, 0, 0, 0);
    cyc(11, 11, 6, 1, 11, 1, 0, 0);
    // R8: load-use from second source
    cyc(1, 2, 12, 3, 0, 0, 0, 0);
    cyc(4, 12, 7, 1, 0, 0, 0, 0);
    cyc(4, 12, 7, 1, 0, 0, 0, 0);
    // mixed traffic on a small register range
    for (int i = 0; i < 400; i++) begin
      cyc($urandom % 4, $urandom % 4, $urandom % 4, $urandom % 4,
          $urandom % 4, $urandom % 2, $urandom % 4, $urandom % 2);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule